// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus side of a small serial memory. It watches the clock and data lines of a two-wire bus, filters noise from both, and recognises the start and stop conditions that frame every transaction. It shifts bytes in and out most significant bit first and acknowledges on the ninth clock. It drives the shared data line only through an open-drain enable, so it can pull the line low or release it. An external pull-up supplies the high level.

The first byte after a start selects the device. A fixed four-bit class code is followed by three bits that must equal the hardwired select pins, and the byte ends in a direction bit. On a write, the next byte is handed to the back end as the word address, and every later byte as data, each through a one-cycle strobe. On a read, the block asks the back end for a byte with a one-cycle request, takes it in that same cycle, and shifts it out. It then keeps reading for as long as the master acknowledges. Address counting and the storage array belong to the back end.

Top module: `twi_slave_front`

## Requirements
- R1: An SDA fall while SCL is high is a start condition and is honoured in every state. It discards any partly received byte and begins receiving a device select byte.
- R2: An SDA rise while SCL is high is a stop condition. It releases SDA and returns the block to idle, and a new transaction can then follow.
- R3: In the device select byte, bits 7:4 are 4'b1010, bits 3:1 equal `dev_pins` and bit 0 is the direction (1 = read, 0 = write). On a match the block holds SDA low for the whole ninth clock.
- R4: When the select byte does not match, the block gives no acknowledge, drives nothing and raises no strobe until the next start.
- R5: In a write, every byte after the select byte is acknowledged. `rx_valid` pulses for one cycle after the falling edge of the eighth SCL of that byte. `rx_byte` holds the byte, assembled MSB first. `rx_first` is 1 only for the first byte after the select byte, which is the word address.
- R6: In a read, `rd_req` pulses for one cycle and `rd_data` is taken in that cycle. The byte is sent MSB first, and SDA changes only after a falling edge of SCL, so it holds steady while SCL is high.
- R7: During a read, a master acknowledge (SDA low on the ninth clock) starts the next byte with a new `rd_req`. A master non-acknowledge makes the block release SDA and stay silent, with no further `rd_req`, until a stop or start.
- R8: On both lines, a pulse shorter than FILT_LEN clocks, measured after the synchronizer, is ignored.
- R9: After reset `sda_oe` is 0 and no strobe is raised. `sda_oe` changes only after a falling edge of SCL or a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| dev_pins | input | 3 | Hardwired low bits of the device select code |
| rx_valid | output | 1 | One-cycle strobe: a written byte is on rx_byte |
| rx_byte | output | 8 | Byte received from the master |
| rx_first | output | 1 | rx_byte is the word address (first byte after select) |
| rd_req | output | 1 | One-cycle request: rd_data is taken in this cycle |
| rd_data | input | 8 | Byte supplied by the back end for a read |

## Verification
The bench issues a repeated start in the middle of a data byte. A design that only honoured starts at byte boundaries would treat the remaining bits as data, shift the next select byte out of alignment and never answer the read. It sends a select byte with the wrong pin bits and then a further byte. A design that compared the wrong field, or forgot the mismatch, would acknowledge or strobe that byte. It ends a read with a non-acknowledge and clocks one more byte, where a design that kept going would pull the line low and raise an extra read request. It also drops a three-clock low pulse onto SDA while SCL is high in the middle of a byte. With a weak filter this would be read as a start followed by a stop, and the byte would be lost.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int PIN_W  = 3;
    localparam logic [3:0] DEV_CLASS = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEVACK,
        ST_WRBYTE,
        ST_WRACK,
        ST_RDBYTE,
        ST_RDACK,
        ST_IGNORE
    } twi_state_e;

    typedef struct packed {
        twi_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               oe;
        logic               rw;
        logic               first;
        logic               more;
        logic               rx_v;
        logic               rd_r;
    } eng_s;

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 5,
    parameter logic RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   out_d, out_q;
    logic                   sample;

    assign sample = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], din};
        cnt_d  = cnt_q;
        out_d  = out_q;
        if (sample == out_q) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            out_d = sample;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RESET_VAL}};
            cnt_q  <= '0;
            out_q  <= RESET_VAL;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> out_q == $past(sample)); // R8
    AST_FILT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(FILT_LEN)); // R8

endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl;
        sda_d = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_c  = scl & scl_q & sda_q & ~sda;
    assign stop_c   = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/twi_engine.sv
module twi_engine
    import twi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_c,
    input  logic               stop_c,
    input  logic               sda,
    input  logic [PIN_W-1:0]   dev_pins,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               rx_valid,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_first,
    output logic               rd_req
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_s d, q;

    always_comb begin
        d      = q;
        d.rx_v = 1'b0;
        d.rd_r = 1'b0;
        if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_c) begin
            d.st    = ST_DEVSEL;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.first = 1'b1;
        end else begin
            case (q.st)
                ST_DEVSEL, ST_WRBYTE: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (q.st == ST_DEVSEL) begin
                            if (q.sh[BYTE_W-1:1] == {DEV_CLASS, dev_pins}) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = ST_DEVACK;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else begin
                            d.rx_v = 1'b1;
                            d.oe   = 1'b1;
                            d.st   = ST_WRACK;
                        end
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.rd_r = 1'b1;
                            d.sh   = rd_data;
                            d.oe   = ~rd_data[BYTE_W-1];
                            d.st   = ST_RDBYTE;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WRBYTE;
                        end
                    end
                end
                ST_WRACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.first = 1'b0;
                        d.st    = ST_WRBYTE;
                    end
                end
                ST_RDBYTE: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RDACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        d.more = ~sda;
                    end else if (scl_fall) begin
                        if (q.more) begin
                            d.rd_r = 1'b1;
                            d.sh   = rd_data;
                            d.oe   = ~rd_data[BYTE_W-1];
                            d.cnt  = '0;
                            d.st   = ST_RDBYTE;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.oe;
    assign rx_valid = q.rx_v;
    assign rx_byte  = q.sh;
    assign rx_first = q.first;
    assign rd_req   = q.rd_r;

    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall || start_c || stop_c)); // R9
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!q.oe && q.st == ST_IDLE)); // R2
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !stop_c) |=> (q.st == ST_DEVSEL && q.cnt == '0)); // R1
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IGNORE |-> (!q.oe && !q.rx_v && !q.rd_r)); // R4
    AST_RX_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_v |-> (q.oe && q.st == ST_WRACK)); // R5
    AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_r |-> (q.st == ST_RDBYTE && q.cnt == '0)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.rx_v, q.rd_r})); // R7

endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front
    import twi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [PIN_W-1:0]   dev_pins,
    output logic               rx_valid,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_first,
    output logic               rd_req,
    input  logic [BYTE_W-1:0]  rd_data
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw, flt;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign raw = {scl_i, sda_i};

    for (genvar i = 0; i < N_LINES; i++) begin : g_filt
        twi_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RESET_VAL   (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[i]),
            .dout  (flt[i])
        );
    end

    twi_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (flt[1]),
        .sda      (flt[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    twi_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .sda      (flt[0]),
        .dev_pins (dev_pins),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_first (rx_first),
        .rd_req   (rd_req)
    );

endmodule

// File: tb/sim_twi_slave_front.sv
module sim_twi_slave_front;

    localparam int Q = 16;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, rx_valid, rx_first, rd_req;
    logic [7:0] rx_byte, rd_data;
    wire sda_line = m_sda & ~sda_oe;

    logic [7:0] bmem [256];
    logic [7:0] bptr = 8'h00;
    logic [8:0] exp_q [$];
    int n_chk = 0;
    int n_err = 0;
    int rd_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twi_slave_front u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .dev_pins (PINS),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_first (rx_first),
        .rd_req   (rd_req),
        .rd_data  (rd_data)
    );

    assign rd_data = bmem[bptr];

    function automatic logic [7:0] init_val(int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor and back-end model
    always @(posedge clk) begin
        if (rx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R4/R5 unexpected rx_valid", {rx_first, rx_byte}, 9'h1ff);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R5 rx first/byte", {rx_first, rx_byte}, e);
            end
            if (rx_first) bptr <= rx_byte;
            else begin
                bmem[bptr] <= rx_byte;
                bptr <= bptr + 8'd1;
            end
        end
        if (rd_req) begin
            rd_cnt++;
            bptr <= bptr + 8'd1;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(logic [7:0] b, int n, bit gl);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq();
            if (gl && i == 6) begin
                m_sda = 1'b0;
                repeat (3) @(negedge clk);
                m_sda = 1'b1;
            end
            wq();
            m_scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(logic [7:0] b, bit gl, output logic ack);
        send_bits(b, 8, gl);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = sda_line;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(bit m_ack, output logic [7:0] b, output bit steady);
        logic a0, a1;
        steady = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1;
            repeat (Q / 2) @(negedge clk);
            a0 = sda_line;
            repeat (Q + Q / 2) @(negedge clk);
            a1 = sda_line;
            if (a0 != a1) steady = 1'b0;
            b[i] = a1;
            m_scl = 1'b0;
        end
        wq();
        m_sda = ~m_ack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        bit st;
        for (int i = 0; i < 256; i++) bmem[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset state
        chk("R9 sda_oe after reset", sda_oe, 0);
        chk("R9 strobes after reset", {rx_valid, rd_req}, 0);

        // Write address 0x10, data A5, 3C
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        chk("R3 select ack", ack, 0);
        exp_q.push_back({1'b1, 8'h10});
        send_byte(8'h10, 1'b0, ack);
        chk("R5 address ack", ack, 0);
        exp_q.push_back({1'b0, 8'hA5});
        send_byte(8'hA5, 1'b0, ack);
        chk("R5 data ack", ack, 0);
        exp_q.push_back({1'b0, 8'h3C});
        send_byte(8'h3C, 1'b0, ack);
        chk("R5 data ack 2", ack, 0);
        bus_stop();
        chk("R2 released after stop", sda_oe, 0);

        // Random read with repeated start after address
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        exp_q.push_back({1'b1, 8'h10});
        send_byte(8'h10, 1'b0, ack);
        bus_start();
        send_byte(DEV_R, 1'b0, ack);
        chk("R3 read select ack", ack, 0);
        recv_byte(1'b1, rb, st);
        chk("R6 first read byte", rb, 8'hA5);
        chk("R6 data steady while SCL high", st, 1);
        recv_byte(1'b0, rb, st);
        chk("R7 byte after master ack", rb, 8'h3C);
        chk("R7 read requests", rd_cnt, 2);
        recv_byte(1'b0, rb, st);
        chk("R7 silent after nack", rb, 8'hFF);
        chk("R7 no request after nack", rd_cnt, 2);
        bus_stop();

        // Mismatching select byte
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, 1'b0, ack);
        chk("R4 no ack on mismatch", ack, 1);
        send_byte(8'h77, 1'b0, ack);
        chk("R4 no ack after mismatch", ack, 1);
        bus_stop();
        chk("R4 no strobe after mismatch", exp_q.size(), 0);

        // Start in the middle of a byte
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        exp_q.push_back({1'b1, 8'h20});
        send_byte(8'h20, 1'b0, ack);
        send_bits(8'hFF, 3, 1'b0);
        bus_start();
        send_byte(DEV_R, 1'b0, ack);
        chk("R1 select after mid-byte start", ack, 0);
        recv_byte(1'b0, rb, st);
        chk("R1 read after mid-byte start", rb, init_val(8'h20));
        bus_stop();

        // Glitch on SDA while SCL high
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        exp_q.push_back({1'b1, 8'h30});
        send_byte(8'h30, 1'b0, ack);
        exp_q.push_back({1'b0, 8'h5A});
        send_byte(8'h5A, 1'b1, ack);
        chk("R8 byte acked despite glitch", ack, 0);
        bus_stop();

        // Stop in the middle of a byte, then a new transaction
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        send_bits(8'hF0, 4, 1'b0);
        bus_stop();
        chk("R2 released after mid-byte stop", sda_oe, 0);
        bus_start();
        send_byte(DEV_W, 1'b0, ack);
        chk("R2 new transaction after stop", ack, 0);
        bus_stop();

        repeat (20) @(negedge clk);
        chk("R5 all expected bytes seen", exp_q.size(), 0);
        chk("R6 total read requests", rd_cnt, 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule